// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is the control core of a small synchronous burst memory whose data output flows through without an output register. On every rising clock it looks at the chip enable, two chip selects, two address strobes with different rules, a step input, the write controls and a sleep input. It sorts the cycle into one of five kinds: deselect, begin-read, begin-write, continue-burst or suspend-burst. The cycle kind, the address load and address step decisions are visible on the ports before the edge. A four-beat burst counter then produces the word address, in either linear or interleaved order.

Write decisions become a registered per-lane strobe vector. This vector updates a byte-lane array one edge after the controls were sampled, using the write data present at that later edge. Read data for the current burst address appears combinationally in the same cycle. The read data is driven only when a burst is active, the output drive input is low, no lane write is pending and the block is awake. Whenever it is not driven, the read data is forced to zero.

A processor-side strobe is honoured only while the chip enable is low, and it always begins a read. A controller-side strobe may begin a write. When the sleep input is high, the edges are frozen.

Top module: `sbsram_cycle_ctrl`

## Requirements
- R1: The chip counts as selected only when en_n=0, sel_p=1 and sel_n=0. The cycle is a deselect (cycle_kind=0) in either of two cases: en_n=1 with ctl_stb_n=0, or en_n=0 while not selected with either strobe low. After a deselect edge no burst is active and rd_drive=0. With both strobes seen as high and no burst active, the kind is also 0.
- R2: When selected with cpu_stb_n=0, a burst begins at addr (cycle_kind=1). All write inputs are ignored for that edge, so wr_strobe is 0 after it.
- R3: When selected with cpu_stb_n=1 and ctl_stb_n=0, a burst begins at addr. The kind is begin-write (2) if the write gating of R6 enables any lane, and begin-read (1) otherwise.
- R4: With both strobes seen as high during an active burst, the cycle is continue (kind 3, addr_step=1) when step_n=0 and suspend (kind 4, address held) when step_n=1. While en_n=1, cpu_stb_n is treated as high. The write gating of R6 applies to both kinds.
- R5: Word address = upper bits of the loaded address, with the low two bits equal to start+n mod 4 when order_lin=1 and start XOR n when order_lin=0, where n counts continue edges. The order wraps after four beats.
- R6: wr_all_n=0 enables all lanes. Otherwise lane_en_n=0 enables lane i when lane_sel_n[i]=0, and lane_en_n=1 enables no lane. Lane i is data bits [9i+8:9i].
- R7: wr_strobe holds the lane mask decided at the last edge. At the next edge the enabled lanes of the current word take wr_data.
- R8: rd_data shows the current word in the same cycle as the edge that set the address, with no added register.
- R9: rd_drive = active burst AND drive_n=0 AND wr_strobe=0 AND nap=0. rd_data is 0 whenever rd_drive=0.
- R10: While nap=1, edges change no state (array, address, strobes, active flag). rd_drive=0, cycle_kind=0, and addr_load and addr_step are 0.
- R11: After reset no burst is active, wr_strobe=0 and rd_drive=0.
- R12: addr_load=1 exactly for begin cycles and addr_step=1 exactly for continue cycles, combinationally from the current inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_n | input | 1 | Chip enable, active low; gates the processor strobe |
| sel_p | input | 1 | Chip select, active high |
| sel_n | input | 1 | Chip select, active low |
| cpu_stb_n | input | 1 | Processor-side address strobe, active low |
| ctl_stb_n | input | 1 | Controller-side address strobe, active low |
| step_n | input | 1 | Burst step, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| lane_en_n | input | 1 | Enables per-lane selects, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| drive_n | input | 1 | Asynchronous output drive enable, active low |
| nap | input | 1 | Sleep: freezes state and blanks output |
| order_lin | input | 1 | 1 = linear burst order, 0 = interleaved |
| addr | input | ADDR_W | Burst start address |
| wr_data | input | LANES*LANE_W | Write data, sampled at the strobe edge |
| cycle_kind | output | 3 | 0 deselect, 1 begin-read, 2 begin-write, 3 continue, 4 suspend |
| addr_load | output | 1 | Next edge loads addr |
| addr_step | output | 1 | Next edge advances the burst |
| wr_strobe | output | LANES | Registered lane write strobes |
| rd_drive | output | 1 | Read data bus drive enable |
| rd_data | output | LANES*LANE_W | Flow-through read data |

## Verification
The first set of patterns covers strobe combinations. Each strobe is tried with the chip enabled, disabled and half-selected, which separates the gated processor strobe from the ungated controller strobe. It also shows that the processor strobe ignores a global write. The write controls are tried as global, masked per-lane and blocked. Read-back of the array then shows exactly which lanes changed.

Bursts are run from non-aligned start addresses in both orders and mixed with suspends. Because every word holds distinct content, the returned data exposes the address sequence.

Further patterns drive the output enable high, apply sleep in the middle of a burst with write requests present, and run a long pseudo-random mix. The random mix is compared on every clock against a behavioural model.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    typedef enum logic [2:0] {
        CYC_DESEL    = 3'd0,
        CYC_BEGIN_RD = 3'd1,
        CYC_BEGIN_WR = 3'd2,
        CYC_CONT     = 3'd3,
        CYC_SUSP     = 3'd4
    } cyc_kind_e;

    typedef struct packed {
        cyc_kind_e kind;
        logic      load;
        logic      step;
        logic      activate;
        logic      release_n;
    } cyc_ctl_t;

    localparam int BEAT_W = 2;

    function automatic logic [BEAT_W-1:0] burst_low(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat,
        input logic              lin
    );
        return lin ? (start + beat) : (start ^ beat);
    endfunction

endpackage

// File: rtl/sbsram_cyc_decode.sv
module sbsram_cyc_decode
    import sbsram_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             en_n,
    input  logic             sel_p,
    input  logic             sel_n,
    input  logic             cpu_stb_n,
    input  logic             ctl_stb_n,
    input  logic             step_n,
    input  logic             wr_all_n,
    input  logic             lane_en_n,
    input  logic [LANES-1:0] lane_sel_n,
    input  logic             nap,
    input  logic             active,
    output cyc_ctl_t         ctl,
    output logic [LANES-1:0] wr_mask
);

    logic             selected;
    logic [LANES-1:0] gate;
    logic             drop_cycle;

    assign selected = !en_n && sel_p && !sel_n;

    // layered write gating: global beats per-lane, per-lane needs lane enable
    always_comb begin
        if (!wr_all_n)       gate = '1;
        else if (!lane_en_n) gate = ~lane_sel_n;
        else                 gate = '0;
    end

    assign drop_cycle = (en_n && !ctl_stb_n) ||
                        (!en_n && !selected && (!cpu_stb_n || !ctl_stb_n));

    always_comb begin
        ctl.kind      = CYC_DESEL;
        ctl.load      = 1'b0;
        ctl.step      = 1'b0;
        ctl.activate  = 1'b0;
        ctl.release_n = 1'b1;
        wr_mask       = '0;
        if (nap) begin
            ctl.release_n = 1'b1;
        end else if (drop_cycle) begin
            ctl.release_n = 1'b0;
        end else if (selected && !cpu_stb_n) begin
            ctl.kind     = CYC_BEGIN_RD;
            ctl.load     = 1'b1;
            ctl.activate = 1'b1;
        end else if (selected && !ctl_stb_n) begin
            ctl.kind     = (|gate) ? CYC_BEGIN_WR : CYC_BEGIN_RD;
            ctl.load     = 1'b1;
            ctl.activate = 1'b1;
            wr_mask      = gate;
        end else if (active) begin
            wr_mask = gate;
            if (!step_n) begin
                ctl.kind = CYC_CONT;
                ctl.step = 1'b1;
            end else begin
                ctl.kind = CYC_SUSP;
            end
        end else begin
            ctl.release_n = 1'b0;
        end
    end

endmodule

// File: rtl/sbsram_burst_addr.sv
module sbsram_burst_addr
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              load,
    input  logic              step,
    input  logic              order_lin,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] word_addr
);

    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            beat_q <= '0;
        end else if (!hold) begin
            if (load) begin
                base_q <= addr_in;
                beat_q <= '0;
            end else if (step) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    assign word_addr = {base_q[ADDR_W-1:BEAT_W],
                        burst_low(base_q[BEAT_W-1:0], beat_q, order_lin)};

endmodule

// File: rtl/sbsram_lane_array.sv
module sbsram_lane_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    hold,
    input  logic [LANES-1:0]        mask_in,
    input  logic [ADDR_W-1:0]       word_addr,
    input  logic [LANES*LANE_W-1:0] wr_data,
    output logic [LANES-1:0]        strobe_q,
    output logic [LANES*LANE_W-1:0] rd_word
);

    localparam int DEPTH = 1 << ADDR_W;

    always_ff @(posedge clk) begin
        if (rst)        strobe_q <= '0;
        else if (!hold) strobe_q <= mask_in;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (!hold && strobe_q[g])
                cells[word_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        assign rd_word[g*LANE_W +: LANE_W] = cells[word_addr];
    end

endmodule

// File: rtl/sbsram_cycle_ctrl.sv
module sbsram_cycle_ctrl
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en_n,
    input  logic                    sel_p,
    input  logic                    sel_n,
    input  logic                    cpu_stb_n,
    input  logic                    ctl_stb_n,
    input  logic                    step_n,
    input  logic                    wr_all_n,
    input  logic                    lane_en_n,
    input  logic [LANES-1:0]        lane_sel_n,
    input  logic                    drive_n,
    input  logic                    nap,
    input  logic                    order_lin,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wr_data,
    output logic [2:0]              cycle_kind,
    output logic                    addr_load,
    output logic                    addr_step,
    output logic [LANES-1:0]        wr_strobe,
    output logic                    rd_drive,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int DATA_W = LANES * LANE_W;

    cyc_ctl_t          ctl;
    logic [LANES-1:0]  wr_mask;
    logic              active_q;
    logic [ADDR_W-1:0] word_addr;
    logic [DATA_W-1:0] rd_word;

    sbsram_cyc_decode #(.LANES(LANES)) u_decode (
        .en_n       (en_n),
        .sel_p      (sel_p),
        .sel_n      (sel_n),
        .cpu_stb_n  (cpu_stb_n),
        .ctl_stb_n  (ctl_stb_n),
        .step_n     (step_n),
        .wr_all_n   (wr_all_n),
        .lane_en_n  (lane_en_n),
        .lane_sel_n (lane_sel_n),
        .nap        (nap),
        .active     (active_q),
        .ctl        (ctl),
        .wr_mask    (wr_mask)
    );

    always_ff @(posedge clk) begin
        if (rst)               active_q <= 1'b0;
        else if (!nap) begin
            if (ctl.activate)        active_q <= 1'b1;
            else if (!ctl.release_n) active_q <= 1'b0;
        end
    end

    sbsram_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .hold      (nap),
        .load      (ctl.load),
        .step      (ctl.step),
        .order_lin (order_lin),
        .addr_in   (addr),
        .word_addr (word_addr)
    );

    sbsram_lane_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_array (
        .clk       (clk),
        .rst       (rst),
        .hold      (nap),
        .mask_in   (wr_mask),
        .word_addr (word_addr),
        .wr_data   (wr_data),
        .strobe_q  (wr_strobe),
        .rd_word   (rd_word)
    );

    assign cycle_kind = ctl.kind;
    assign addr_load  = ctl.load;
    assign addr_step  = ctl.step;
    assign rd_drive   = active_q && !drive_n && !nap && (wr_strobe == '0);
    assign rd_data    = rd_drive ? rd_word : '0;

endmodule

// File: rtl/sbsram_cycle_ctrl_chk.sv
module sbsram_cycle_ctrl_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             en_n,
    input logic             sel_p,
    input logic             sel_n,
    input logic             cpu_stb_n,
    input logic             ctl_stb_n,
    input logic             wr_all_n,
    input logic             drive_n,
    input logic             nap,
    input logic [LANES-1:0] wr_strobe,
    input logic             rd_drive,
    input logic [2:0]       cycle_kind,
    input logic             addr_load
);

    logic chosen;
    assign chosen = !en_n && sel_p && !sel_n;

    a_r1_desel_kind: assert property (@(posedge clk) disable iff (rst)
        (en_n && !ctl_stb_n) |-> (cycle_kind == 3'd0));

    a_r1_desel_quiet: assert property (@(posedge clk) disable iff (rst)
        (!nap && en_n && !ctl_stb_n) |=> !rd_drive);

    a_r2_cpu_no_write: assert property (@(posedge clk) disable iff (rst)
        (!nap && chosen && !cpu_stb_n) |=> (wr_strobe == '0));

    a_r6_global_all: assert property (@(posedge clk) disable iff (rst)
        (!nap && chosen && cpu_stb_n && !ctl_stb_n && !wr_all_n) |=> (&wr_strobe));

    a_r9_write_blanks: assert property (@(posedge clk) disable iff (rst)
        (wr_strobe != '0) |-> !rd_drive);

    a_r9_drive_off: assert property (@(posedge clk) disable iff (rst)
        drive_n |-> !rd_drive);

    a_r10_nap_quiet: assert property (@(posedge clk) disable iff (rst)
        nap |-> (!rd_drive && !addr_load));

    a_r10_nap_hold: assert property (@(posedge clk) disable iff (rst)
        nap |=> $stable(wr_strobe));

endmodule

bind sbsram_cycle_ctrl sbsram_cycle_ctrl_chk #(.LANES(LANES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en_n       (en_n),
    .sel_p      (sel_p),
    .sel_n      (sel_n),
    .cpu_stb_n  (cpu_stb_n),
    .ctl_stb_n  (ctl_stb_n),
    .wr_all_n   (wr_all_n),
    .drive_n    (drive_n),
    .nap        (nap),
    .wr_strobe  (wr_strobe),
    .rd_drive   (rd_drive),
    .cycle_kind (cycle_kind),
    .addr_load  (addr_load)
);

// File: tb/sbsram_cycle_ctrl_tb.sv
`timescale 1ns/1ps
module sbsram_cycle_ctrl_tb;

    localparam int ADDR_W = 6;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int DATA_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_n, sel_p, sel_n, cpu_stb_n, ctl_stb_n, step_n;
    logic wr_all_n, lane_en_n, drive_n, nap, order_lin;
    logic [LANES-1:0]  lane_sel_n;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wr_data;
    logic [2:0]        cycle_kind;
    logic              addr_load, addr_step, rd_drive;
    logic [LANES-1:0]  wr_strobe;
    logic [DATA_W-1:0] rd_data;

    always #5 clk = ~clk;

    sbsram_cycle_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dut (
        .clk(clk), .rst(rst), .en_n(en_n), .sel_p(sel_p), .sel_n(sel_n),
        .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .step_n(step_n),
        .wr_all_n(wr_all_n), .lane_en_n(lane_en_n), .lane_sel_n(lane_sel_n),
        .drive_n(drive_n), .nap(nap), .order_lin(order_lin), .addr(addr),
        .wr_data(wr_data), .cycle_kind(cycle_kind), .addr_load(addr_load),
        .addr_step(addr_step), .wr_strobe(wr_strobe), .rd_drive(rd_drive),
        .rd_data(rd_data)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    string ctx = "";

    // behavioural reference state
    logic [DATA_W-1:0] m_mem [DEPTH];
    bit                m_active;
    logic [ADDR_W-1:0] m_base;
    int                m_beat;
    logic [LANES-1:0]  m_pend;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s (%s) actual=%0h expected=%0h at %0t", tag, ctx, act, exp, $time);
        end
    endtask

    function automatic logic [ADDR_W-1:0] m_word();
        logic [1:0] lo;
        if (order_lin) lo = m_base[1:0] + 2'(m_beat);
        else           lo = m_base[1:0] ^ 2'(m_beat);
        return {m_base[ADDR_W-1:2], lo};
    endfunction

    task automatic m_decode(output int k, output bit ld, output bit st, output logic [LANES-1:0] mk);
        bit chosen;
        logic [LANES-1:0] g;
        chosen = !en_n && sel_p && !sel_n;
        if (!wr_all_n)       g = '1;
        else if (!lane_en_n) g = ~lane_sel_n;
        else                 g = '0;
        k = 0; ld = 0; st = 0; mk = '0;
        if (nap) k = 0;
        else if (en_n && !ctl_stb_n) k = 0;
        else if (!en_n && !chosen && (!cpu_stb_n || !ctl_stb_n)) k = 0;
        else if (chosen && !cpu_stb_n) begin k = 1; ld = 1; end
        else if (chosen && !ctl_stb_n) begin
            ld = 1; mk = g; k = (g != 0) ? 2 : 1;
        end else if (m_active) begin
            mk = g;
            if (!step_n) begin k = 3; st = 1; end
            else k = 4;
        end
    endtask

    function automatic string kind_tag(input int k);
        case (k)
            0: return nap ? "R10" : "R1";
            1: return "R2";
            2: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic step();
        int k; bit ld, st; logic [LANES-1:0] mk;
        logic [DATA_W-1:0] exp_d;
        bit exp_drv;
        #1;
        m_decode(k, ld, st, mk);
        check(cycle_kind == 3'(k), kind_tag(k), 64'(cycle_kind), 64'(k));
        check(addr_load == ld, nap ? "R10" : "R12", 64'(addr_load), 64'(ld));
        check(addr_step == st, nap ? "R10" : "R12", 64'(addr_step), 64'(st));
        @(posedge clk);
        if (!nap) begin
            for (int i = 0; i < LANES; i++)
                if (m_pend[i]) m_mem[m_word()][i*LANE_W +: LANE_W] = wr_data[i*LANE_W +: LANE_W];
            if (ld) begin m_base = addr; m_beat = 0; m_active = 1; end
            else if (st) m_beat = (m_beat + 1) % 4;
            if (k == 0) m_active = 0;
            m_pend = mk;
        end
        @(negedge clk);
        exp_drv = m_active && !drive_n && !nap && (m_pend == 0);
        exp_d   = exp_drv ? m_mem[m_word()] : '0;
        check(wr_strobe == m_pend, "R7", 64'(wr_strobe), 64'(m_pend));
        check(rd_drive == exp_drv, "R9", 64'(rd_drive), 64'(exp_drv));
        check(rd_data == exp_d, exp_drv ? "R8" : "R9", 64'(rd_data), 64'(exp_d));
    endtask

    task automatic idle();
        en_n = 1; sel_p = 1; sel_n = 0; cpu_stb_n = 1; ctl_stb_n = 1; step_n = 1;
        wr_all_n = 1; lane_en_n = 1; lane_sel_n = '1; drive_n = 0; nap = 0;
    endtask

    function automatic logic [DATA_W-1:0] rnd_data();
        return DATA_W'({$urandom, $urandom});
    endfunction

    task automatic begin_cpu(input logic [ADDR_W-1:0] a);
        idle(); en_n = 0; cpu_stb_n = 0; addr = a; step();
    endtask

    task automatic begin_ctl(input logic [ADDR_W-1:0] a, input bit wall);
        idle(); en_n = 0; ctl_stb_n = 0; wr_all_n = !wall; addr = a; wr_data = rnd_data(); step();
    endtask

    task automatic cont(input bit adv, input bit wall);
        idle(); step_n = !adv; wr_all_n = !wall; wr_data = rnd_data(); step();
    endtask

    task automatic flush();
        idle(); ctl_stb_n = 0; wr_data = rnd_data(); step();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired (R11) actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        m_active = 0; m_base = '0; m_beat = 0; m_pend = '0;
        idle(); order_lin = 1; addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        ctx = "R11 reset state";
        #1;
        check(wr_strobe == '0, "R11", 64'(wr_strobe), 64'd0);
        check(rd_drive == 1'b0, "R11", 64'(rd_drive), 64'd0);
        check(rd_data == '0, "R11", 64'(rd_data), 64'd0);
        @(negedge clk);

        // fill the whole array with global-write bursts
        ctx = "R3 R7 fill";
        for (int b = 0; b < DEPTH; b += 4) begin
            begin_ctl(ADDR_W'(b), 1);
            for (int j = 0; j < 3; j++) cont(1, 1);
        end
        flush();

        ctx = "R5 linear burst";
        order_lin = 1;
        begin_cpu(6'd5);
        for (int j = 0; j < 4; j++) cont(1, 0);
        cont(0, 0);
        ctx = "R5 interleaved burst";
        order_lin = 0;
        begin_cpu(6'd22);
        for (int j = 0; j < 4; j++) cont(1, 0);
        cont(0, 0); cont(1, 0);

        ctx = "R2 cpu strobe ignores global write";
        idle(); en_n = 0; cpu_stb_n = 0; wr_all_n = 0; addr = 6'd9; step();
        cont(0, 0);

        ctx = "R6 lane write";
        idle(); en_n = 0; ctl_stb_n = 0; lane_en_n = 0; lane_sel_n = 4'b1010;
        addr = 6'd12; step();
        idle(); wr_data = rnd_data(); step();
        ctx = "R6 lanes blocked";
        idle(); lane_en_n = 1; lane_sel_n = 4'b0000; step_n = 0; step();
        begin_cpu(6'd12); cont(1, 0);

        ctx = "R1 half-selected deselect";
        idle(); en_n = 0; sel_p = 0; cpu_stb_n = 0; step();
        cont(1, 0); cont(0, 1);
        begin_cpu(6'd3);
        idle(); en_n = 0; sel_n = 1; ctl_stb_n = 0; step();
        ctx = "R1 disabled cpu strobe ignored";
        begin_cpu(6'd40);
        idle(); cpu_stb_n = 0; step_n = 0; step();

        ctx = "R9 drive off";
        idle(); drive_n = 1; step();
        idle(); step();

        ctx = "R10 nap";
        begin_cpu(6'd33);
        cont(1, 0);
        for (int j = 0; j < 3; j++) begin
            idle(); nap = 1; en_n = 0; ctl_stb_n = 0; wr_all_n = 0; addr = 6'd33;
            wr_data = rnd_data(); step();
        end
        flush();
        begin_cpu(6'd33); cont(1, 0);

        ctx = "R4 random mix";
        for (int seg = 0; seg < 2; seg++) begin
            order_lin = (seg == 0);
            for (int c = 0; c < 400; c++) begin
                en_n       = ($urandom % 4) == 0;
                sel_p      = ($urandom % 8) != 0;
                sel_n      = ($urandom % 8) == 0;
                cpu_stb_n  = ($urandom % 4) != 0;
                ctl_stb_n  = ($urandom % 4) != 0;
                step_n     = ($urandom % 2) != 0;
                wr_all_n   = ($urandom % 4) != 0;
                lane_en_n  = ($urandom % 2) != 0;
                lane_sel_n = LANES'($urandom);
                drive_n    = ($urandom % 5) == 0;
                nap        = ($urandom % 16) == 0;
                addr       = ADDR_W'($urandom);
                wr_data    = rnd_data();
                step();
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule